// File: doc/BRIEF.md
# Planar Graphics Controller Datapath

This block connects an 8-bit CPU data path to four 8-bit video memory planes that share one byte address. A CPU memory read captures the addressed byte from all four planes into a 32-bit latch and hands back the byte of one chosen plane. A CPU memory write produces four plane bytes in the same cycle. Each plane's byte starts from either the CPU data, rotated right by a programmed count, or a solid fill taken from a 4-bit colour. It is then combined with that plane's latched byte by a programmable logic function. A bit mask decides, bit by bit, whether the computed value or the latched value reaches memory.

Software programs the block through two I/O ports. The index port (address 0x3CE) selects one of nine 8-bit control registers. The data port (address 0x3CF) reads or writes the register that is selected. A 16-bit write to the index port carries the index in its low byte and the value in its high byte, so both arrive in one transaction.

Top module: `pgc_datapath`

## Requirements
- R1: After reset the index and every control register read back as 0x00, except the bit mask (index 8), which reads back as 0xFF.
- R2: A byte write to the index port 0x3CE stores the index. A read of the index port returns that index. A byte write to the data port 0x3CF loads the indexed register, and a read of the data port returns it. Indices: 0 fill colour, 1 fill enable, 2 compare colour, 3 rotate/function, 4 plane select, 5 mode, 6 misc, 7 don't-care, 8 bit mask.
- R3: A 16-bit write to the index port (io_wide=1) stores io_wdata[7:0] as the index and writes io_wdata[15:8] into the register that index names, all in the same cycle.
- R4: Only bits 3:0 of the fill colour (index 0) and fill enable (index 1) are stored. Bits 7:4 of both read back as zero.
- R5: A data-port write while the index is above 8 changes no register, and a data-port read at such an index returns 0x00.
- R6: mem_rd loads the latch from plane_rdata at the clock edge. Plane p occupies bits 8p+7:8p. mem_rdata presents latch byte number rms[1:0] of the plane select register and keeps its value until the next mem_rd.
- R7: For each plane p whose fill-enable bit p is 1, the source byte is 0xFF when fill-colour bit p is 1 and 0x00 when it is 0.
- R8: For planes with fill enable 0, the source byte is mem_wdata rotated right by bits 2:0 of register 3.
- R9: Bits 4:3 of register 3 select how the source combines with the latched byte: 00 passes the source, 01 ANDs, 10 ORs, 11 XORs.
- R10: Where a bit-mask bit is 0, the plane output bit equals the latched bit. Where it is 1, the output bit is the function result.
- R11: plane_wr follows mem_wr. All four bytes of plane_wdata are valid in that same cycle.
- R12: A register write and a memory write in the same cycle give a write result that uses the register value before the update. A mem_rd together with a mem_wr merges against the latch as it stood before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wide | input | 1 | I/O write carries 16 bits |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when not reading a decoded port |
| mem_rd | input | 1 | CPU memory read strobe |
| mem_wr | input | 1 | CPU memory write strobe |
| mem_wdata | input | 8 | CPU memory write byte |
| mem_rdata | output | 8 | Byte of the selected plane from the latch |
| plane_rdata | input | 32 | Byte read from all four planes |
| plane_wr | output | 1 | Write strobe to all four planes |
| plane_wdata | output | 32 | Bytes to write to the four planes |

## Verification
Two kinds of same-cycle overlap can occur. A control register update can coincide with a memory write, and a latch reload can coincide with a memory write. In both cases the write path must see the state from before the edge. The bench sets up the first overlap by issuing a 16-bit write that clears the bit mask in the same cycle as a memory write. It then expects the full CPU byte to reach the planes in that cycle and only latched data in the next. It sets up the second overlap by asserting mem_rd and mem_wr together with a zero mask. It expects the old latch contents on plane_wdata, and the new plane data on mem_rdata one cycle later.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int NPLANE   = 4;
    localparam int BYTE_W   = 8;
    localparam int BUS_W    = NPLANE * BYTE_W;
    localparam int ROT_W    = $clog2(BYTE_W);
    localparam int NREG     = 9;
    localparam int SEL_W    = $clog2(NPLANE);

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic [NPLANE-1:0] fill;
        logic [NPLANE-1:0] fill_en;
        logic [BYTE_W-1:0] cmp;
        logic [BYTE_W-1:0] rotfn;
        logic [BYTE_W-1:0] rms;
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] misc;
        logic [BYTE_W-1:0] dontcare;
        logic [BYTE_W-1:0] bmask;
    } ctrl_regs_t;

    function automatic logic [BYTE_W-1:0] rot_right(input logic [BYTE_W-1:0] d,
                                                    input logic [ROT_W-1:0] n);
        logic [2*BYTE_W-1:0] t;
        t = {d, d} >> n;
        return t[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] alu_apply(input alu_fn_e fn,
                                                    input logic [BYTE_W-1:0] s,
                                                    input logic [BYTE_W-1:0] l);
        logic [BYTE_W-1:0] r;
        case (fn)
            FN_AND:  r = s & l;
            FN_OR:   r = s | l;
            FN_XOR:  r = s ^ l;
            default: r = s;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pgc_regfile.sv
module pgc_regfile
    import pgc_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] IDX_PORT  = 16'h03CE,
    parameter logic [15:0] DATA_PORT = 16'h03CF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic                io_wide,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [2*BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0]   io_rdata,
    output logic [BYTE_W-1:0]   idx_q,
    output ctrl_regs_t          regs_q
);
    logic              hit_idx, hit_data;
    logic              reg_we;
    logic [BYTE_W-1:0] reg_sel, reg_val, rd_val;

    assign hit_idx  = (io_addr == ADDR_W'(IDX_PORT));
    assign hit_data = (io_addr == ADDR_W'(DATA_PORT));

    always_comb begin
        reg_we  = 1'b0;
        reg_sel = idx_q;
        reg_val = io_wdata[BYTE_W-1:0];
        if (io_wr && hit_idx && io_wide) begin
            reg_we  = 1'b1;
            reg_sel = io_wdata[BYTE_W-1:0];
            reg_val = io_wdata[2*BYTE_W-1:BYTE_W];
        end else if (io_wr && hit_data) begin
            reg_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (io_wr && hit_idx) begin
            idx_q <= io_wdata[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q       <= '0;
            regs_q.bmask <= '1;
        end else if (reg_we) begin
            case (reg_sel)
                8'd0: regs_q.fill     <= reg_val[NPLANE-1:0];
                8'd1: regs_q.fill_en  <= reg_val[NPLANE-1:0];
                8'd2: regs_q.cmp      <= reg_val;
                8'd3: regs_q.rotfn    <= reg_val;
                8'd4: regs_q.rms      <= reg_val;
                8'd5: regs_q.mode     <= reg_val;
                8'd6: regs_q.misc     <= reg_val;
                8'd7: regs_q.dontcare <= reg_val;
                8'd8: regs_q.bmask    <= reg_val;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx_q)
            8'd0:    rd_val = BYTE_W'(regs_q.fill);
            8'd1:    rd_val = BYTE_W'(regs_q.fill_en);
            8'd2:    rd_val = regs_q.cmp;
            8'd3:    rd_val = regs_q.rotfn;
            8'd4:    rd_val = regs_q.rms;
            8'd5:    rd_val = regs_q.mode;
            8'd6:    rd_val = regs_q.misc;
            8'd7:    rd_val = regs_q.dontcare;
            8'd8:    rd_val = regs_q.bmask;
            default: rd_val = '0;
        endcase
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && hit_idx)  io_rdata = idx_q;
        if (io_rd && hit_data) io_rdata = rd_val;
    end
endmodule

// File: rtl/pgc_source.sv
module pgc_source
    import pgc_pkg::*;
(
    input  logic [BYTE_W-1:0] cpu_byte,
    input  logic [ROT_W-1:0]  rot_cnt,
    input  logic [NPLANE-1:0] fill,
    input  logic [NPLANE-1:0] fill_en,
    output logic [BUS_W-1:0]  src
);
    logic [BYTE_W-1:0] rotated;

    assign rotated = rot_right(cpu_byte, rot_cnt);

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        assign src[p*BYTE_W +: BYTE_W] = fill_en[p] ? {BYTE_W{fill[p]}} : rotated;
    end
endmodule

// File: rtl/pgc_merge.sv
module pgc_merge
    import pgc_pkg::*;
(
    input  logic [BUS_W-1:0]  src,
    input  logic [BUS_W-1:0]  latch,
    input  logic [1:0]        fn_sel,
    input  logic [BYTE_W-1:0] bmask,
    output logic [BUS_W-1:0]  merged
);
    alu_fn_e fn;
    assign fn = alu_fn_e'(fn_sel);

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [BYTE_W-1:0] res, lat;
        assign lat = latch[p*BYTE_W +: BYTE_W];
        assign res = alu_apply(fn, src[p*BYTE_W +: BYTE_W], lat);
        assign merged[p*BYTE_W +: BYTE_W] = (res & bmask) | (lat & ~bmask);
    end
endmodule

// File: rtl/pgc_datapath.sv
module pgc_datapath
    import pgc_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] IDX_PORT  = 16'h03CE,
    parameter logic [15:0] DATA_PORT = 16'h03CF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic                io_wide,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [2*BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0]   io_rdata,
    input  logic                mem_rd,
    input  logic                mem_wr,
    input  logic [BYTE_W-1:0]   mem_wdata,
    output logic [BYTE_W-1:0]   mem_rdata,
    input  logic [BUS_W-1:0]    plane_rdata,
    output logic                plane_wr,
    output logic [BUS_W-1:0]    plane_wdata
);
    ctrl_regs_t        regs_q;
    logic [BYTE_W-1:0] idx_q;
    logic [BUS_W-1:0]  latch_q;
    logic [BUS_W-1:0]  src;
    logic [SEL_W-1:0]  rd_plane;

    pgc_regfile #(
        .ADDR_W   (ADDR_W),
        .IDX_PORT (IDX_PORT),
        .DATA_PORT(DATA_PORT)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_wide (io_wide),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .idx_q   (idx_q),
        .regs_q  (regs_q)
    );

    always_ff @(posedge clk) begin
        if (rst)         latch_q <= '0;
        else if (mem_rd) latch_q <= plane_rdata;
    end

    assign rd_plane  = regs_q.rms[SEL_W-1:0];
    assign mem_rdata = latch_q[rd_plane*BYTE_W +: BYTE_W];

    pgc_source src_i (
        .cpu_byte(mem_wdata),
        .rot_cnt (regs_q.rotfn[ROT_W-1:0]),
        .fill    (regs_q.fill),
        .fill_en (regs_q.fill_en),
        .src     (src)
    );

    pgc_merge merge_i (
        .src   (src),
        .latch (latch_q),
        .fn_sel(regs_q.rotfn[ROT_W+1:ROT_W]),
        .bmask (regs_q.bmask),
        .merged(plane_wdata)
    );

    assign plane_wr = mem_wr;
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk
    import pgc_pkg::*;
#(
    parameter logic [15:0] DATA_PORT = 16'h03CF
) (
    input logic               clk,
    input logic               rst,
    input logic               io_wr,
    input logic               io_rd,
    input logic               io_wide,
    input logic [15:0]        io_addr,
    input logic [BYTE_W-1:0]  io_rdata,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [BUS_W-1:0]   plane_rdata,
    input logic [BUS_W-1:0]   plane_wdata,
    input logic [BUS_W-1:0]   latch_q,
    input logic [BYTE_W-1:0]  idx_q,
    input ctrl_regs_t         regs_q
);
    // R1
    bmask_after_reset_chk: assert property (@(posedge clk)
        rst |=> (regs_q.bmask == 8'hFF));

    // R4
    fill_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == DATA_PORT && idx_q <= 8'd1) |-> (io_rdata[7:4] == 4'h0));

    // R5
    bad_index_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !io_wide && io_addr == DATA_PORT && idx_q > 8'd8) |=> $stable(regs_q));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_rd |=> $stable(latch_q));

    // R6
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (latch_q == $past(plane_rdata)));

    // R7
    fill_plane0_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && regs_q.fill_en[0] && regs_q.rotfn[4:3] == 2'b00)
        |-> ((plane_wdata[7:0] & regs_q.bmask) == ({8{regs_q.fill[0]}} & regs_q.bmask)));

    // R10
    mask_keeps_latch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (((plane_wdata ^ latch_q) & ~{NPLANE{regs_q.bmask}}) == '0));
endmodule

bind pgc_datapath pgc_chk #(.DATA_PORT(DATA_PORT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wide    (io_wide),
    .io_addr    (io_addr),
    .io_rdata   (io_rdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .plane_rdata(plane_rdata),
    .plane_wdata(plane_wdata),
    .latch_q    (latch_q),
    .idx_q      (idx_q),
    .regs_q     (regs_q)
);

// File: tb/pgc_datapath_tb.sv
module pgc_datapath_tb_top;
    localparam logic [15:0] IDXP = 16'h03CE;
    localparam logic [15:0] DATP = 16'h03CF;
    localparam logic [31:0] LAT0 = 32'hF00FAA55;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0, io_rd = 1'b0, io_wide = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [15:0] io_wdata = 16'h0;
    logic [7:0]  io_rdata;
    logic        mem_rd = 1'b0, mem_wr = 1'b0;
    logic [7:0]  mem_wdata = 8'h0;
    logic [7:0]  mem_rdata;
    logic [31:0] plane_rdata = 32'h0;
    logic        plane_wr;
    logic [31:0] plane_wdata;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pgc_datapath dut_i (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .plane_rdata(plane_rdata), .plane_wr(plane_wr), .plane_wdata(plane_wdata)
    );

    typedef struct packed {
        logic [3:0]  fill;
        logic [3:0]  fill_en;
        logic [7:0]  rotfn;
        logic [7:0]  mask;
        logic [7:0]  data;
        logic [31:0] expect_w;
    } vec_t;

    // Latch holds LAT0 during the walk: p3=F0 p2=0F p1=AA p0=55.
    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{4'h0, 4'h0, 8'h00, 8'hFF, 8'h3C, 32'h3C3C3C3C},  // R9 pass
        '{4'h5, 4'hF, 8'h00, 8'hFF, 8'h00, 32'h00FF00FF},  // R7 fill
        '{4'h0, 4'h0, 8'h01, 8'hFF, 8'h81, 32'hC0C0C0C0},  // R8 rot 1
        '{4'h0, 4'h0, 8'h04, 8'hFF, 8'h12, 32'h21212121},  // R8 rot 4
        '{4'h0, 4'h0, 8'h08, 8'hFF, 8'hFF, 32'hF00FAA55},  // R9 AND
        '{4'h0, 4'h0, 8'h10, 8'hFF, 8'h0F, 32'hFF0FAF5F},  // R9 OR
        '{4'h0, 4'h0, 8'h18, 8'hFF, 8'hFF, 32'h0FF055AA},  // R9 XOR
        '{4'h0, 4'h0, 8'h00, 8'h0F, 8'h00, 32'hF000A050},  // R10 half mask
        '{4'h0, 4'h0, 8'h00, 8'h00, 8'hFF, 32'hF00FAA55},  // R10 zero mask
        '{4'h3, 4'h6, 8'h18, 8'hF0, 8'h3C, 32'hC00F5A65},  // R7 R9 R10 mixed
        '{4'h0, 4'h0, 8'h0B, 8'hFF, 8'h0F, 32'hE001A041}   // R8 R9 rot 3 AND
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wide_wr(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        io_wr = 1'b1; io_wide = 1'b1; io_addr = IDXP; io_wdata = {val, idx};
        @(negedge clk);
        io_wr = 1'b0; io_wide = 1'b0;
    endtask

    task automatic byte_wr(input logic [15:0] port, input logic [7:0] val);
        @(negedge clk);
        io_wr = 1'b1; io_wide = 1'b0; io_addr = port; io_wdata = {8'h00, val};
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic port_rd(input logic [15:0] port, output logic [7:0] val);
        @(negedge clk);
        io_rd = 1'b1; io_addr = port;
        #1 val = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] val);
        byte_wr(IDXP, idx);
        port_rd(DATP, val);
    endtask

    task automatic load_latch(input logic [31:0] v);
        @(negedge clk);
        plane_rdata = v; mem_rd = 1'b1;
        @(negedge clk);
        mem_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int i = 0; i <= 8; i++) begin
            reg_rd(8'(i), v);
            check($sformatf("R1 reg %0d", i), 32'(v), (i == 8) ? 32'hFF : 32'h0);
        end

        // R2 byte index/data access
        byte_wr(IDXP, 8'd5);
        port_rd(IDXP, v);
        check("R2 index readback", 32'(v), 32'h05);
        byte_wr(DATP, 8'hA7);
        port_rd(DATP, v);
        check("R2 data readback", 32'(v), 32'hA7);

        // R3 wide write sets index and value together
        wide_wr(8'd7, 8'h5C);
        port_rd(IDXP, v);
        check("R3 index from wide", 32'(v), 32'h07);
        port_rd(DATP, v);
        check("R3 value from wide", 32'(v), 32'h5C);

        // R4 upper bits of fill and fill enable
        wide_wr(8'd0, 8'hFF);
        reg_rd(8'd0, v);
        check("R4 fill", 32'(v), 32'h0F);
        wide_wr(8'd1, 8'hF9);
        reg_rd(8'd1, v);
        check("R4 fill enable", 32'(v), 32'h09);

        // R5 index above 8
        wide_wr(8'd2, 8'h33);
        byte_wr(IDXP, 8'd9);
        byte_wr(DATP, 8'h77);
        port_rd(DATP, v);
        check("R5 read at index 9", 32'(v), 32'h00);
        reg_rd(8'd2, v);
        check("R5 cmp untouched", 32'(v), 32'h33);
        reg_rd(8'd8, v);
        check("R5 mask untouched", 32'(v), 32'hFF);
        reg_rd(8'd5, v);
        check("R5 mode untouched", 32'(v), 32'hA7);
        wide_wr(8'd12, 8'h44);
        reg_rd(8'd4, v);
        check("R5 wide above 8", 32'(v), 32'h00);

        // R6 latch and plane select
        load_latch(LAT0);
        plane_rdata = 32'h0;
        for (int p = 0; p < 4; p++) begin
            wide_wr(8'd4, 8'(p));
            #1 check($sformatf("R6 plane %0d", p), 32'(mem_rdata), 32'((LAT0 >> (8*p)) & 32'hFF));
        end
        wide_wr(8'd4, 8'hFD);
        #1 check("R6 select low bits only", 32'(mem_rdata), 32'hAA);

        // Write path table walk
        for (int k = 0; k < NVEC; k++) begin
            wide_wr(8'd0, 8'(VEC[k].fill));
            wide_wr(8'd1, 8'(VEC[k].fill_en));
            wide_wr(8'd3, VEC[k].rotfn);
            wide_wr(8'd8, VEC[k].mask);
            @(negedge clk);
            mem_wr = 1'b1; mem_wdata = VEC[k].data;
            #1 check($sformatf("R7-R10 vector %0d", k), plane_wdata, VEC[k].expect_w);
            check("R11 strobe with write", 32'(plane_wr), 32'h1);
            @(negedge clk);
            mem_wr = 1'b0;
            #1 check("R11 strobe idle", 32'(plane_wr), 32'h0);
        end

        // R12 register update in same cycle as write
        wide_wr(8'd0, 8'h0); wide_wr(8'd1, 8'h0);
        wide_wr(8'd3, 8'h0); wide_wr(8'd8, 8'hFF);
        @(negedge clk);
        io_wr = 1'b1; io_wide = 1'b1; io_addr = IDXP; io_wdata = {8'h00, 8'd8};
        mem_wr = 1'b1; mem_wdata = 8'h3C;
        #1 check("R12 old mask used", plane_wdata, 32'h3C3C3C3C);
        @(negedge clk);
        io_wr = 1'b0; io_wide = 1'b0;
        #1 check("R12 new mask after edge", plane_wdata, LAT0);
        // R12 read and write together
        @(negedge clk);
        mem_rd = 1'b1; plane_rdata = 32'h12345678;
        #1 check("R12 write merges old latch", plane_wdata, LAT0);
        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0;
        wide_wr(8'd4, 8'd0);
        #1 check("R12 new latch visible", 32'(mem_rdata), 32'h78);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        reg_rd(8'd8, v);
        check("R1 mask after reset", 32'(v), 32'hFF);
        reg_rd(8'd3, v);
        check("R1 rotfn after reset", 32'(v), 32'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule